// File: doc/BRIEF.md
# Scalar Register Arithmetic Unit

This unit holds a bank of sixteen scalar registers that sequencing logic uses for loop bounds, address offsets and delay counts. Each cycle it accepts one command made of a 3-bit operation code, two 7-bit operand fields with one source flag each, and a 4-bit destination index. The flag selects how its field is read. When clear, the field is a zero-extended immediate. When set, the field names a register. The unit computes the result and writes it to the destination register.

The pipeline has a single stage. The result is captured at the clock edge that ends the command cycle and is committed to the bank at the following edge. While a write is pending it is forwarded to every read: the two operand reads, the read of the old destination value that the fused modes need, and the external read port. A command can therefore depend on the command issued in the cycle before it, and another block can observe a new value one edge after issuing the command that produced it.

Top module: `scu_top`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers to zero and cancels any pending write. After reset, the read port returns zero for every index.
- R2: The operand flag selects the source of each operand, independently for the two operands. With the flag at 0, the 7-bit field is zero-extended to the 16-bit register width. With the flag at 1, the low 4 bits of the field index a register and the upper 3 bits are ignored.
- R3: Operation code 1 writes a+b. Operation code 2 writes a-b. Both results are taken modulo 2^16.
- R4: Operation code 3 shifts a right arithmetically and operation code 4 shifts a left. The shift distance is the low 3 bits of b, and the upper bits of b are ignored.
- R5: Operation code 5 writes the low 16 bits of a*b.
- R6: Operation code 6 writes a*b+d and operation code 7 writes d-a*b, where d is the destination's value before the command. Both results are truncated to 16 bits.
- R7: Operation code 0 writes no register.
- R8: The result goes to the register chosen by the 4-bit destination field. It is visible on the read port from the first clock edge after the command (forwarded), and the register holds it afterwards.
- R9: A command issued in the cycle right after another sees that command's result in its operand and destination reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_mode | input | 3 | Operation code (0 means no operation) |
| cmd_a_reg | input | 1 | Operand a source flag (1 = register) |
| cmd_a | input | 7 | Operand a field |
| cmd_b_reg | input | 1 | Operand b source flag (1 = register) |
| cmd_b | input | 7 | Operand b field |
| cmd_dest | input | 4 | Destination register index |
| rd_idx | input | 4 | External read index |
| rd_data | output | 16 | External read data, with the pending write forwarded |

## Verification
The bench seeds the registers with both positive and negative values. It then sweeps every non-idle operation code across all four combinations of the source flags, with operand fields whose unused upper bits are set. A design that sign-extended immediates would give wrong sums. A design that shifted logically, or that used the whole b field as the shift distance, would give wrong shift results. A design that read the destination after the write would give wrong fused results. The result is read in the cycle immediately after each command, so a design without forwarding would return stale values. Back-to-back dependent commands catch a design that fails to forward to the operand reads. Idle commands aimed at registers that hold data catch a design that writes anyway.

// File: rtl/scu_pkg.sv
package scu_pkg;

    localparam int SCU_OP_W = 3;
    localparam int SCU_SH_W = 3;

    typedef enum logic [SCU_OP_W-1:0] {
        OP_NONE = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SRA  = 3'd3,
        OP_SLL  = 3'd4,
        OP_MUL  = 3'd5,
        OP_MAC  = 3'd6,
        OP_MSB  = 3'd7
    } scu_op_e;

    function automatic logic op_writes(input scu_op_e op);
        return op != OP_NONE;
    endfunction

endpackage

// File: rtl/scu_opsel.sv
module scu_opsel #(
    parameter int DATA_W  = 16,
    parameter int FIELD_W = 7,
    parameter int IDX_W   = 4
) (
    input  logic               is_reg,
    input  logic [FIELD_W-1:0] field,
    input  logic [DATA_W-1:0]  reg_val,
    output logic [IDX_W-1:0]   idx,
    output logic [DATA_W-1:0]  value
);
    // register index comes from the low bits of the field
    assign idx   = field[IDX_W-1:0];
    assign value = is_reg ? reg_val : DATA_W'(field);
endmodule

// File: rtl/scu_alu.sv
module scu_alu
    import scu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  scu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] res
);
    logic [SCU_SH_W-1:0] sh;
    logic [DATA_W-1:0]   prod;

    assign sh   = b[SCU_SH_W-1:0];
    assign prod = a * b;

    always_comb begin
        unique case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_SRA:  res = DATA_W'($signed(a) >>> sh);
            OP_SLL:  res = a << sh;
            OP_MUL:  res = prod;
            OP_MAC:  res = prod + d;
            OP_MSB:  res = d - prod;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/scu_regbank.sv
module scu_regbank #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    parameter int NRD      = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_dat,
    input  logic [NRD-1:0][IDX_W-1:0]    rd_idx,
    output logic [NRD-1:0][DATA_W-1:0]   rd_dat
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[r] <= '0;
            else if (wr_en && wr_idx == IDX_W'(r))
                regs[r] <= wr_dat;
        end
    end

    // every read port sees the write that commits at the next edge
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (wr_en && wr_idx == rd_idx[p])
                rd_dat[p] = wr_dat;
            else
                rd_dat[p] = regs[rd_idx[p]];
        end
    end
endmodule

// File: rtl/scu_top.sv
module scu_top
    import scu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    parameter int FIELD_W  = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SCU_OP_W-1:0]         cmd_mode,
    input  logic                        cmd_a_reg,
    input  logic [FIELD_W-1:0]          cmd_a,
    input  logic                        cmd_b_reg,
    input  logic [FIELD_W-1:0]          cmd_b,
    input  logic [$clog2(NUM_REGS)-1:0] cmd_dest,
    input  logic [$clog2(NUM_REGS)-1:0] rd_idx,
    output logic [DATA_W-1:0]           rd_data
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int NRD   = 4;
    localparam int PA = 0, PB = 1, PD = 2, PX = 3;

    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] dat;
    } wb_t;

    scu_op_e                   op;
    wb_t                       wb_q;
    logic [NRD-1:0][IDX_W-1:0]  rdi;
    logic [NRD-1:0][DATA_W-1:0] rdd;
    logic [IDX_W-1:0]          a_idx, b_idx;
    logic [DATA_W-1:0]         a_val, b_val, res;
    logic                      wb_vld;
    logic [IDX_W-1:0]          wb_idx;
    logic [DATA_W-1:0]         wb_dat;

    assign op = scu_op_e'(cmd_mode);

    scu_opsel #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_sel_a (
        .is_reg(cmd_a_reg), .field(cmd_a), .reg_val(rdd[PA]),
        .idx(a_idx), .value(a_val)
    );

    scu_opsel #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_sel_b (
        .is_reg(cmd_b_reg), .field(cmd_b), .reg_val(rdd[PB]),
        .idx(b_idx), .value(b_val)
    );

    assign rdi[PA] = a_idx;
    assign rdi[PB] = b_idx;
    assign rdi[PD] = cmd_dest;
    assign rdi[PX] = rd_idx;

    scu_regbank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NRD(NRD)) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(wb_q.vld), .wr_idx(wb_q.idx), .wr_dat(wb_q.dat),
        .rd_idx(rdi), .rd_dat(rdd)
    );

    scu_alu #(.DATA_W(DATA_W)) u_alu (
        .op(op), .a(a_val), .b(b_val), .d(rdd[PD]), .res(res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_q <= '0;
        end else begin
            wb_q.vld <= op_writes(op);
            wb_q.idx <= cmd_dest;
            wb_q.dat <= res;
        end
    end

    assign rd_data = rdd[PX];
    assign wb_vld  = wb_q.vld;
    assign wb_idx  = wb_q.idx;
    assign wb_dat  = wb_q.dat;
endmodule

// File: rtl/scu_chk.sv
module scu_chk #(
    parameter int DATA_W  = 16,
    parameter int FIELD_W = 7,
    parameter int IDX_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [2:0]         cmd_mode,
    input logic               cmd_a_reg,
    input logic [FIELD_W-1:0] cmd_a,
    input logic               cmd_b_reg,
    input logic [FIELD_W-1:0] cmd_b,
    input logic [IDX_W-1:0]   cmd_dest,
    input logic [IDX_W-1:0]   rd_idx,
    input logic [DATA_W-1:0]  rd_data,
    input logic               wb_vld,
    input logic [IDX_W-1:0]   wb_idx,
    input logic [DATA_W-1:0]  wb_dat
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!wb_vld && rd_data == '0));

    // R7
    idle_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_mode == 3'd0) |=> !wb_vld);

    // R8
    dest_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_mode != 3'd0) |=> (wb_vld && wb_idx == $past(cmd_dest)));

    // R8
    fwd_read_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_vld && rd_idx == wb_idx) |-> (rd_data == wb_dat));

    // R3
    imm_add_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_mode == 3'd1 && !cmd_a_reg && !cmd_b_reg) |=>
        (wb_dat == DATA_W'($past(cmd_a)) + DATA_W'($past(cmd_b))));

    // R4
    imm_shl_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_mode == 3'd4 && !cmd_a_reg && !cmd_b_reg) |=>
        (wb_dat == (DATA_W'($past(cmd_a)) << $past(cmd_b[2:0]))));
endmodule

bind scu_top scu_chk #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst(rst), .cmd_mode(cmd_mode),
    .cmd_a_reg(cmd_a_reg), .cmd_a(cmd_a),
    .cmd_b_reg(cmd_b_reg), .cmd_b(cmd_b),
    .cmd_dest(cmd_dest), .rd_idx(rd_idx), .rd_data(rd_data),
    .wb_vld(wb_vld), .wb_idx(wb_idx), .wb_dat(wb_dat)
);

// File: tb/scu_top_tb_top.sv
module scu_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd_mode = '0;
    logic        cmd_a_reg = 1'b0;
    logic [6:0]  cmd_a = '0;
    logic        cmd_b_reg = 1'b0;
    logic [6:0]  cmd_b = '0;
    logic [3:0]  cmd_dest = '0;
    logic [3:0]  rd_idx = '0;
    logic [15:0] rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [15:0] mdl [16];

    always #2 clk = ~clk;

    scu_top dut_i (
        .clk(clk), .rst(rst), .cmd_mode(cmd_mode),
        .cmd_a_reg(cmd_a_reg), .cmd_a(cmd_a),
        .cmd_b_reg(cmd_b_reg), .cmd_b(cmd_b),
        .cmd_dest(cmd_dest), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input int m);
        case (m)
            1, 2:    return "R3";
            3, 4:    return "R4";
            5:       return "R5";
            6, 7:    return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [15:0] model_res(input int m, input logic [15:0] a,
                                              input logic [15:0] b, input logic [15:0] d);
        logic signed [15:0] s;
        logic [31:0] p;
        int sh;
        sh = int'(b % 16'd8);
        s  = a;
        p  = {16'd0, a} * {16'd0, b};
        case (m)
            1: return a + b;
            2: return a - b;
            3: return 16'(s >>> sh);
            4: return a << sh;
            5: return p[15:0];
            6: return p[15:0] + d;
            7: return d - p[15:0];
            default: return d;
        endcase
    endfunction

    // drive at a falling edge; result is read one edge later via forwarding (R8)
    task automatic issue(input int m, input int fa, input int a, input int fb, input int b,
                         input int dest, input string tag);
        logic [15:0] va, vb, nv;
        va = fa != 0 ? mdl[a % 16] : 16'(a % 128);
        vb = fb != 0 ? mdl[b % 16] : 16'(b % 128);
        nv = model_res(m, va, vb, mdl[dest]);
        cmd_mode  = 3'(m);
        cmd_a_reg = fa[0];
        cmd_a     = 7'(a);
        cmd_b_reg = fb[0];
        cmd_b     = 7'(b);
        cmd_dest  = 4'(dest);
        rd_idx    = 4'(dest);
        if (m != 0) mdl[dest] = nv;
        @(posedge clk);
        @(negedge clk);
        check(rd_data, mdl[dest], tag);
    endtask

    task automatic sweep_bank(input string tag);
        cmd_mode = 3'd0;
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            #1;
            check(rd_data, mdl[i], tag);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: all registers read zero after reset
        sweep_bank("R1");

        // seed: alternate add and subtract of immediates, giving negative values too
        for (int i = 0; i < 16; i++)
            issue((i % 2) != 0 ? 2 : 1, 0, (i * 29 + 3) % 128, 0, (i * 71) % 128, i, "R8");

        // R2: register index uses only the low 4 bits of the field
        issue(1, 1, 7'h7A, 0, 0, 2, "R2");
        issue(1, 0, 7'h7F, 1, 7'h35, 3, "R2");

        // main sweep: every operation, all flag combinations
        for (int m = 1; m < 8; m++)
            for (int fa = 0; fa < 2; fa++)
                for (int fb = 0; fb < 2; fb++)
                    for (int k = 0; k < 12; k++)
                        issue(m, fa, (k * 37 + m * 11 + fa * 5) % 128, fb,
                              (k * 53 + m * 7 + fb * 3) % 128, (k * 5 + m) % 16,
                              (fa + fb) != 0 ? {mode_tag(m), "/R2"} : mode_tag(m));

        // R4: shift distance limited to 3 bits, arithmetic fill of a negative value
        issue(2, 0, 0, 0, 1, 9, "R3");
        issue(3, 1, 9, 0, 7'h7B, 9, "R4");
        issue(4, 0, 7'h41, 0, 7'h0F, 10, "R4");

        // R9: dependent commands in consecutive cycles
        issue(1, 0, 12, 0, 5, 5, "R9");
        issue(6, 1, 5, 0, 3, 5, "R9");
        issue(7, 1, 5, 1, 5, 5, "R9");
        issue(1, 1, 5, 1, 5, 6, "R9");

        // R7: idle commands leave their destination unchanged
        for (int i = 0; i < 16; i++)
            issue(0, 0, 7'h55, 1, i, i, "R7");

        // R8: bank holds every committed value
        sweep_bank("R8");

        done = 1'b1;
        summary();
    end
endmodule